// File: doc/BRIEF.md
# Row-Scan Refresh and Brightness Timer

This block produces the timing for a multiplexed LED dot-matrix display. Rows are lit one at a time. The block counts display clocks, divides each refresh into eight equal row slots and drives one row enable per slot. Each enable stays high for the first part of its slot. The length of that high time comes from a 4-bit brightness code, which selects an entry in a fixed nonlinear table. The index of the row being scanned is also an output, so a separate column datapath can present the matching dot data.

A clock-enable style oscillator input sets the timing. With the internal source selected, every system clock counts as one oscillator cycle. With the external source selected, only cycles on which the external tick input is high count, and an optional divide-by-eight prescaler may be placed in that path.

Two inputs turn the display dark. A sleep input stops the oscillator path, so the counters hold and all rows go dark. A blank input turns off every row enable while the counters keep running.

Top module: `row_scan_pwm`

## Requirements
- R1: A synchronous reset clears the prescaler, the cycle counter and the row index to zero. After the reset edge, `row_idx` is 0 and `row_en` is all zero.
- R2: Each row slot lasts 64 display ticks. `row_idx` steps 0,1,...,7 and then wraps to 0, so one full refresh takes 512 display ticks.
- R3: With `use_ext_osc` low, every clock is an oscillator cycle. With `use_ext_osc` high, only clocks with `ext_osc_tick` high are oscillator cycles.
- R4: With `use_ext_osc` and `prescale_en` both high, one display tick occurs per 8 oscillator cycles, so a refresh takes 4096 external ticks. The first tick after reset comes on the 8th external pulse.
- R5: `prescale_en` has no effect while `use_ext_osc` is low.
- R6: The row enable of the current row is high while the cycle count within the slot is below the on-time for `brightness`. Codes 0 to 15 give on-times of 0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60 display ticks.
- R7: Brightness code 0 keeps every row enable low.
- R8: `row_en[0]` is never high. At most one bit of `row_en` is high, and that bit is the one at position `row_idx`.
- R9: While `sleep_n` is low, the prescaler, the cycle counter and the row index hold their values and `row_en` is all zero. Counting resumes from the held state when `sleep_n` returns high.
- R10: While `blank` is high, `row_en` is all zero, but the counters keep advancing.
- R11: `row_idx` always presents the row currently being scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| use_ext_osc | input | 1 | 1 selects the external oscillator tick, 0 selects the internal source |
| ext_osc_tick | input | 1 | One external oscillator cycle per high clock |
| prescale_en | input | 1 | Divide the external oscillator by 8 |
| sleep_n | input | 1 | 0 stops the oscillator and darkens the display |
| blank | input | 1 | 1 forces every row enable low |
| brightness | input | 4 | Brightness code selecting the on-time |
| row_idx | output | 3 | Row currently scanned |
| row_en | output | 8 | One enable per row; bit 0 is the unused row |

## Verification
The checker enforces the following on every cycle:
- row 0 stays dark and at most one row enable is high;
- a dark output whenever sleep, blank or code 0 applies;
- a held row index while asleep;
- a row index that only ever moves up by one;
- the cleared state after reset.

Some behaviours can only be shown by the bench's scenarios, which follow a reference timeline cycle by cycle:
- the exact slot length of 64 ticks;
- the on-time for each of the sixteen codes;
- the eight-to-one prescale ratio and its first tick after reset;
- the fact that the prescaler is ignored on the internal source;
- resumption from the held state after sleep.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

   localparam int unsigned BR_W   = 4;
   localparam int unsigned ONT_W  = 8;
   localparam int unsigned MAX_ON = 60;

   // nonlinear brightness curve: code -> lit display ticks per slot
   function automatic logic [ONT_W-1:0] on_time(input logic [BR_W-1:0] code);
      logic [ONT_W-1:0] t;
      case (code)
         4'd0:  t = 8'd0;
         4'd1:  t = 8'd1;
         4'd2:  t = 8'd2;
         4'd3:  t = 8'd3;
         4'd4:  t = 8'd4;
         4'd5:  t = 8'd5;
         4'd6:  t = 8'd7;
         4'd7:  t = 8'd9;
         4'd8:  t = 8'd11;
         4'd9:  t = 8'd14;
         4'd10: t = 8'd18;
         4'd11: t = 8'd22;
         4'd12: t = 8'd28;
         4'd13: t = 8'd36;
         4'd14: t = 8'd48;
         default: t = 8'd60;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/rsp_prescaler.sv
module rsp_prescaler #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic osc_tick,
   input  logic div_en,
   output logic disp_tick
);

   generate
      if (DIV < 1) begin : g_bad
         $error("rsp_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_bypass
         assign disp_tick = osc_tick;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         logic          wrap;

         assign wrap = (cnt_q == CW'(DIV - 1));

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (osc_tick && div_en) begin
               cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
         end

         assign disp_tick = osc_tick && (!div_en || wrap);
      end
   endgenerate

endmodule

// File: rtl/rsp_slot_counter.sv
module rsp_slot_counter #(
   parameter int unsigned ROWS     = 8,
   parameter int unsigned SLOT_CYC = 64,
   localparam int unsigned ROW_W   = $clog2(ROWS),
   localparam int unsigned CYC_W   = $clog2(SLOT_CYC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [CYC_W-1:0] cyc,
   output logic [ROW_W-1:0] row
);

   logic [CYC_W-1:0] cyc_q;
   logic [ROW_W-1:0] row_q;
   logic             slot_end;
   logic             frame_end;

   assign slot_end  = (cyc_q == CYC_W'(SLOT_CYC - 1));
   assign frame_end = (row_q == ROW_W'(ROWS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q <= '0;
         row_q <= '0;
      end else if (tick) begin
         if (slot_end) begin
            cyc_q <= '0;
            row_q <= frame_end ? '0 : row_q + 1'b1;
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end

   assign cyc = cyc_q;
   assign row = row_q;

endmodule

// File: rtl/rsp_row_driver.sv
module rsp_row_driver #(
   parameter int unsigned ROWS      = 8,
   parameter int unsigned SLOT_CYC  = 64,
   parameter int unsigned DARK_ROW  = 0,
   localparam int unsigned ROW_W    = $clog2(ROWS),
   localparam int unsigned CYC_W    = $clog2(SLOT_CYC)
) (
   input  logic                     active,
   input  logic [rsp_pkg::BR_W-1:0] brightness,
   input  logic [ROW_W-1:0]         row,
   input  logic [CYC_W-1:0]         cyc,
   output logic [ROWS-1:0]          row_en
);

   logic [rsp_pkg::ONT_W-1:0] on_cyc;
   logic                      lit;

   assign on_cyc = rsp_pkg::on_time(brightness);
   assign lit    = active && (rsp_pkg::ONT_W'(cyc) < on_cyc);

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         if (r == DARK_ROW) begin : g_dark
            assign row_en[r] = 1'b0;
         end else begin : g_lit
            assign row_en[r] = lit && (row == ROW_W'(r));
         end
      end
   endgenerate

endmodule

// File: rtl/row_scan_pwm.sv
module row_scan_pwm #(
   parameter int unsigned ROWS      = 8,
   parameter int unsigned SLOT_CYC  = 64,
   parameter int unsigned PRE_DIV   = 8,
   parameter int unsigned DARK_ROW  = 0,
   localparam int unsigned ROW_W    = $clog2(ROWS),
   localparam int unsigned CYC_W    = $clog2(SLOT_CYC)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     use_ext_osc,
   input  logic                     ext_osc_tick,
   input  logic                     prescale_en,
   input  logic                     sleep_n,
   input  logic                     blank,
   input  logic [rsp_pkg::BR_W-1:0] brightness,
   output logic [ROW_W-1:0]         row_idx,
   output logic [ROWS-1:0]          row_en
);

   generate
      if (ROWS < 2 || (1 << ROW_W) != ROWS) begin : g_rows_bad
         $error("row_scan_pwm: ROWS must be a power of two, at least 2");
      end
      if ((1 << CYC_W) != SLOT_CYC || SLOT_CYC <= rsp_pkg::MAX_ON) begin : g_slot_bad
         $error("row_scan_pwm: SLOT_CYC must be a power of two above the longest on-time");
      end
      if (DARK_ROW >= ROWS) begin : g_dark_bad
         $error("row_scan_pwm: DARK_ROW out of range");
      end
   endgenerate

   logic             osc_tick;
   logic             div_en;
   logic             disp_tick;
   logic [CYC_W-1:0] cyc;
   logic [ROW_W-1:0] row;

   // sleep gates the oscillator at its source, freezing all counters
   assign osc_tick = sleep_n && (use_ext_osc ? ext_osc_tick : 1'b1);
   assign div_en   = use_ext_osc && prescale_en;

   rsp_prescaler #(.DIV(PRE_DIV)) pre_i (
      .clk       (clk),
      .rst       (rst),
      .osc_tick  (osc_tick),
      .div_en    (div_en),
      .disp_tick (disp_tick)
   );

   rsp_slot_counter #(.ROWS(ROWS), .SLOT_CYC(SLOT_CYC)) cnt_i (
      .clk  (clk),
      .rst  (rst),
      .tick (disp_tick),
      .cyc  (cyc),
      .row  (row)
   );

   rsp_row_driver #(.ROWS(ROWS), .SLOT_CYC(SLOT_CYC), .DARK_ROW(DARK_ROW)) drv_i (
      .active     (sleep_n && !blank),
      .brightness (brightness),
      .row        (row),
      .cyc        (cyc),
      .row_en     (row_en)
   );

   assign row_idx = row;

endmodule

// File: rtl/row_scan_pwm_chk.sv
module row_scan_pwm_chk #(
   parameter int unsigned ROWS  = 8,
   parameter int unsigned ROW_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             sleep_n,
   input logic             blank,
   input logic [3:0]       brightness,
   input logic [ROW_W-1:0] row_idx,
   input logic [ROWS-1:0]  row_en
);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (row_idx == '0 && row_en == '0));

   // R8
   one_row_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_en) && !row_en[0]);

   // R8
   row_match_chk: assert property (@(posedge clk) disable iff (rst)
      (row_en != '0) |-> row_en[row_idx]);

   // R9
   sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !sleep_n |=> $stable(row_idx));

   // R10
   dark_chk: assert property (@(posedge clk) disable iff (rst)
      (blank || !sleep_n) |-> (row_en == '0));

   // R7
   code_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (brightness == 4'd0) |-> (row_en == '0));

   // R2
   row_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && row_idx != $past(row_idx)) |-> (row_idx == $past(row_idx) + 1'b1));

endmodule

bind row_scan_pwm row_scan_pwm_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .sleep_n    (sleep_n),
   .blank      (blank),
   .brightness (brightness),
   .row_idx    (row_idx),
   .row_en     (row_en)
);

// File: tb/row_scan_pwm_tb_top.sv
`timescale 1ns/100ps
module row_scan_pwm_tb_top;

   localparam int ONT [16] = '{0, 1, 2, 3, 4, 5, 7, 9, 11, 14, 18, 22, 28, 36, 48, 60};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       use_ext_osc = 1'b0;
   logic       ext_osc_tick = 1'b0;
   logic       prescale_en = 1'b0;
   logic       sleep_n = 1'b1;
   logic       blank = 1'b0;
   logic [3:0] brightness = 4'd0;
   logic [2:0] row_idx;
   logic [7:0] row_en;

   always #2.5 clk = ~clk;

   row_scan_pwm dut_i (
      .clk          (clk),
      .rst          (rst),
      .use_ext_osc  (use_ext_osc),
      .ext_osc_tick (ext_osc_tick),
      .prescale_en  (prescale_en),
      .sleep_n      (sleep_n),
      .blank        (blank),
      .brightness   (brightness),
      .row_idx      (row_idx),
      .row_en       (row_en)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   logic [2:0] exp_row_q [$];
   logic [7:0] exp_en_q  [$];
   string      exp_tag_q [$];

   // reference timeline
   int  m_pre = 0;
   int  m_cyc = 0;
   int  m_row = 0;
   bit  m_valid = 1'b0;

   task automatic drive(input bit r, input bit ext, input bit et, input bit pre,
                        input bit slp_n, input bit blk, input int br, input string tag);
      logic [7:0] e_en;
      bit         osc;
      bit         tk;
      @(negedge clk);
      rst = r; use_ext_osc = ext; ext_osc_tick = et; prescale_en = pre;
      sleep_n = slp_n; blank = blk; brightness = 4'(br);
      if (m_valid) begin
         e_en = '0;
         if (slp_n && !blk && m_row != 0 && m_cyc < ONT[br]) e_en[m_row] = 1'b1;
         exp_row_q.push_back(3'(m_row));
         exp_en_q.push_back(e_en);
         exp_tag_q.push_back(tag);
      end
      if (r) begin
         m_pre = 0; m_cyc = 0; m_row = 0; m_valid = 1'b1;
      end else begin
         osc = slp_n && (ext ? et : 1'b1);
         tk  = 1'b0;
         if (osc) begin
            if (ext && pre) begin
               if (m_pre == 7) begin m_pre = 0; tk = 1'b1; end
               else m_pre = m_pre + 1;
            end else tk = 1'b1;
         end
         if (tk) begin
            if (m_cyc == 63) begin m_cyc = 0; m_row = (m_row + 1) % 8; end
            else m_cyc = m_cyc + 1;
         end
      end
   endtask

   // monitor: pop one expected item per cycle and compare
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_row_q.size() > 0) begin
            logic [2:0] er;
            logic [7:0] ee;
            string      t;
            er = exp_row_q.pop_front();
            ee = exp_en_q.pop_front();
            t  = exp_tag_q.pop_front();
            n_vec++;
            if (row_idx !== er) begin
               n_bad++;
               $display("FAIL R11/%s row_idx act %0d exp %0d at %0t", t, row_idx, er, $time);
            end
            if (row_en !== ee) begin
               n_bad++;
               $display("FAIL %s row_en act %b exp %b at %0t", t, row_en, ee, $time);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 1, 0, 15, "R1");
      // R2 R3 R8: internal oscillator, full brightness, over a refresh
      for (int i = 0; i < 600; i++) drive(0, 0, 0, 0, 1, 0, 15, "R2");
      // R6 R7: sweep every code over a slot each
      for (int c = 0; c < 16; c++)
         for (int i = 0; i < 64; i++) drive(0, 0, 0, 0, 1, 0, c, c == 0 ? "R7" : "R6");
      // R5: prescale ignored on the internal source
      for (int i = 0; i < 200; i++) drive(0, 0, 0, 1, 1, 0, 13, "R5");
      // R3: external oscillator, pulse on every third clock
      for (int i = 0; i < 400; i++) drive(0, 1, (i % 3) == 0, 0, 1, 0, 12, "R3");
      // R4: reset, then prescaled external with steady pulses
      drive(1, 1, 1, 1, 1, 0, 15, "R1");
      for (int i = 0; i < 4200; i++) drive(0, 1, 1, 1, 1, 0, 15, "R4");
      // R4: prescaled external with sparse pulses
      for (int i = 0; i < 300; i++) drive(0, 1, (i % 2) == 0, 1, 1, 0, 14, "R4");
      // R9: sleep freezes and darkens, then resume
      for (int i = 0; i < 120; i++) drive(0, 0, 0, 0, 0, 0, 15, "R9");
      for (int i = 0; i < 150; i++) drive(0, 0, 0, 0, 1, 0, 15, "R9");
      // R10: blank darkens while counting continues
      for (int i = 0; i < 200; i++) drive(0, 0, 0, 0, 1, 1, 15, "R10");
      for (int i = 0; i < 100; i++) drive(0, 0, 0, 0, 1, 0, 15, "R10");
      // R1: reset mid-run
      drive(1, 0, 0, 0, 1, 0, 15, "R1");
      for (int i = 0; i < 70; i++) drive(0, 0, 0, 0, 1, 0, 15, "R1");
      @(negedge clk);
      @(negedge clk);
      #2;
      finish_run();
   end

endmodule